// File: doc/BRIEF.md
# Pixel Raster Mix Unit

This block is the per-pixel combining stage of a 2-D drawing engine. Each cycle it takes one source pixel and one destination pixel and selects one of two mix codes with a pattern bit. It merges the two pixels with either a Boolean function or a saturating arithmetic function. Where the colour-compare gate holds, it suppresses the write. It then restricts the change to the bit planes that the plane mask allows. The result pixel and its write-enable are registered, so the unit accepts one pixel per cycle with one cycle of latency.

Pixels may be 1, 2, 4, 8 or 16 bits wide. Every operand is truncated to the selected width before use. Arithmetic functions run over a ripple chain in which a carry-chain mask can cut the carry between any two adjacent bits. This lets packed sub-fields be added independently. Pattern fetch, memory access and address generation are outside this block.

Top module: `pix_mix_unit`

## Requirements
- R1: Outputs are registered: `out_valid` equals `in_valid` from the previous cycle. `out_pix` and `out_we` reflect the inputs of that same previous cycle. While `rst_n` is low at a clock edge, `out_valid`, `out_we` and `out_pix` become 0.
- R2: Size code 0/1/2/3/4 selects a pixel width of 1/2/4/8/16 bits, and codes 5 to 7 also select 16 bits. Source, destination and compare colour are truncated to that width. Bits of `out_pix` above the width are 0.
- R3: Mix codes 0x00 to 0x0F give these Boolean results: 0x0 zero, 0x1 S&D, 0x2 S&~D, 0x3 S, 0x4 ~S&D, 0x5 D, 0x6 S^D, 0x7 S|D, 0x8 ~S&~D, 0x9 S^~D, 0xA ~D, 0xB S|~D, 0xC ~S, 0xD ~S|D, 0xE ~S|~D, 0xF all ones.
- R4: Code 0x10 gives the unsigned maximum of S and D, and code 0x11 gives the unsigned minimum.
- R5: Code 0x12 gives S+D clamped to the all-ones value of the width. Code 0x13 gives D−S clamped at 0, and code 0x14 gives S−D clamped at 0.
- R6: Code 0x15 gives floor((S+D)/2), and the carry out of the top bit becomes the result's top bit.
- R7: In arithmetic codes, a carry leaves bit n for bit n+1 only when `carry_mask[n]` is 1. The carry out of the top pixel bit always decides saturation and averaging.
- R8: Codes 0x16 to 0x1F give the destination unchanged.
- R9: `pat_bit`=1 selects `fg_mix`, and `pat_bit`=0 selects `bg_mix`.
- R10: Compare condition codes are 0 true, 1 D>C, 2 D==C, 3 D<C, 4 false, 5 D>=C, 6 D!=C and 7 D<=C, all unsigned. `out_we` is 1 only for a valid pixel whose condition is false.
- R11: Each output bit whose `plane_mask` bit is 0 equals the destination bit, and every other bit takes the mix result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| src_pix | input | 16 | Source pixel |
| dst_pix | input | 16 | Destination pixel |
| size_code | input | 3 | Pixel width code |
| fg_mix | input | 5 | Mix code used when the pattern bit is 1 |
| bg_mix | input | 5 | Mix code used when the pattern bit is 0 |
| pat_bit | input | 1 | Pattern bit |
| cc_cond | input | 3 | Compare condition code |
| cc_color | input | 16 | Compare colour |
| plane_mask | input | 16 | Bits allowed to change |
| carry_mask | input | 16 | Carry enables between adjacent bits |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 16 | Pixel to write |
| out_we | output | 1 | Write enable |

## Verification
The bench targets saturation at both ends: a sum past all-ones, and a difference below zero. A design that lets the result wrap would write a small value or a large one in place of the clamp. An average of two all-ones pixels checks that the top carry is kept, since losing it would halve the result. A cut carry chain must drop the carry across the masked bit, which an unmasked ripple would not do. Truncation is checked at 1, 2 and 4 bits, and it is also checked in the compare, where a design that compares untruncated values would block the wrong pixels.

// File: rtl/pix_mix_pkg.sv
// Package: shared mix-code constants and the width helper for the pixel mix unit.
// Assumes mix codes are 5 bits wide and compare codes are 3 bits wide.
package pix_mix_pkg;
    localparam int MIX_W  = 5;
    localparam int COND_W = 3;
    localparam int SIZE_W = 3;

    typedef enum logic [2:0] {
        AR_MAX  = 3'd0,
        AR_MIN  = 3'd1,
        AR_ADD  = 3'd2,
        AR_DMS  = 3'd3,
        AR_SMD  = 3'd4,
        AR_AVG  = 3'd5
    } arith_op_e;

    localparam logic [MIX_W-1:0] LAST_ARITH = 5'h15;
endpackage

// File: rtl/pix_logic_op.sv
// Module: the sixteen Boolean functions of source and destination.
// Assumes operands are already truncated; the caller masks the result to width.
module pix_logic_op #(
    parameter int PIX_W = 16
) (
    input  logic [3:0]       op,
    input  logic [PIX_W-1:0] s,
    input  logic [PIX_W-1:0] d,
    output logic [PIX_W-1:0] y
);
    // Select the Boolean function given by the code.
    always_comb begin
        unique case (op)
            4'h0: y = '0;
            4'h1: y = s & d;
            4'h2: y = s & ~d;
            4'h3: y = s;
            4'h4: y = ~s & d;
            4'h5: y = d;
            4'h6: y = s ^ d;
            4'h7: y = s | d;
            4'h8: y = ~s & ~d;
            4'h9: y = s ^ ~d;
            4'hA: y = ~d;
            4'hB: y = s | ~d;
            4'hC: y = ~s;
            4'hD: y = ~s | d;
            4'hE: y = ~s | ~d;
            default: y = '1;
        endcase
    end
endmodule

// File: rtl/pix_arith_op.sv
// Module: arithmetic mixes (max, min, saturating add/subtract, average).
// Assumes s and d are truncated to the width and top_idx is that width minus one.
// The carry chain is cut at each bit whose carry-mask bit is clear; the carry out
// of bit top_idx is taken before the mask and decides clamping and averaging.
module pix_arith_op #(
    parameter int PIX_W = 16,
    localparam int IDX_W = $clog2(PIX_W)
) (
    input  logic [2:0]       op,
    input  logic [PIX_W-1:0] s,
    input  logic [PIX_W-1:0] d,
    input  logic [PIX_W-1:0] wmask,
    input  logic [IDX_W-1:0] top_idx,
    input  logic [PIX_W-1:0] cmask,
    output logic [PIX_W-1:0] y
);
    import pix_mix_pkg::*;

    // Ripple chain with per-bit carry gating; returns {top carry, sum}.
    function automatic logic [PIX_W:0] chain(
        input logic [PIX_W-1:0] a,
        input logic [PIX_W-1:0] b,
        input logic             cin,
        input logic [PIX_W-1:0] cm,
        input logic [IDX_W-1:0] top
    );
        logic [PIX_W-1:0] sum;
        logic             c;
        logic             g;
        logic             tc;
        c  = cin;
        tc = 1'b0;
        for (int i = 0; i < PIX_W; i++) begin
            sum[i] = a[i] ^ b[i] ^ c;
            g      = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
            if (i == int'(top)) tc = g;
            c      = g & cm[i];
        end
        return {tc, sum};
    endfunction

    logic [PIX_W:0]   add_r;
    logic [PIX_W:0]   dms_r;
    logic [PIX_W:0]   smd_r;
    logic [PIX_W-1:0] avg_v;
    logic [PIX_W-1:0] top_bit;

    // Run the three chains the arithmetic codes need.
    always_comb begin
        add_r   = chain(s, d, 1'b0, cmask, top_idx);
        dms_r   = chain(d, ~s & wmask, 1'b1, cmask, top_idx);
        smd_r   = chain(s, ~d & wmask, 1'b1, cmask, top_idx);
        top_bit = {{(PIX_W-1){1'b0}}, add_r[PIX_W]} << top_idx;
        avg_v   = (add_r[PIX_W-1:0] >> 1) | top_bit;
    end

    // Pick and clamp the result for the selected arithmetic code.
    always_comb begin
        case (arith_op_e'(op))
            AR_MAX:  y = (s > d) ? s : d;
            AR_MIN:  y = (s < d) ? s : d;
            AR_ADD:  y = add_r[PIX_W] ? wmask : add_r[PIX_W-1:0];
            AR_DMS:  y = dms_r[PIX_W] ? dms_r[PIX_W-1:0] : '0;
            AR_SMD:  y = smd_r[PIX_W] ? smd_r[PIX_W-1:0] : '0;
            AR_AVG:  y = avg_v;
            default: y = d;
        endcase
    end
endmodule

// File: rtl/pix_cmp_gate.sv
// Module: colour-compare gate; a held condition blocks the write.
// Assumes dst and color are already truncated to the pixel width.
module pix_cmp_gate #(
    parameter int PIX_W = 16
) (
    input  logic [2:0]       cond,
    input  logic [PIX_W-1:0] dst,
    input  logic [PIX_W-1:0] color,
    output logic             block
);
    // Evaluate the unsigned compare condition.
    always_comb begin
        unique case (cond)
            3'd0: block = 1'b1;
            3'd1: block = dst > color;
            3'd2: block = dst == color;
            3'd3: block = dst < color;
            3'd4: block = 1'b0;
            3'd5: block = dst >= color;
            3'd6: block = dst != color;
            default: block = dst <= color;
        endcase
    end
endmodule

// File: rtl/pix_mix_unit.sv
// Module: top of the pixel raster mix unit. Truncates operands to the pixel
// width, selects the mix code by pattern bit, combines, gates by compare and
// plane mask, and registers the pixel and write-enable.
// Assumes PIX_W is a power of two; size codes above log2(PIX_W) use PIX_W.
module pix_mix_unit #(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] src_pix,
    input  logic [PIX_W-1:0] dst_pix,
    input  logic [2:0]       size_code,
    input  logic [4:0]       fg_mix,
    input  logic [4:0]       bg_mix,
    input  logic             pat_bit,
    input  logic [2:0]       cc_cond,
    input  logic [PIX_W-1:0] cc_color,
    input  logic [PIX_W-1:0] plane_mask,
    input  logic [PIX_W-1:0] carry_mask,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_we
);
    import pix_mix_pkg::*;

    localparam int IDX_W  = $clog2(PIX_W);
    localparam int MAX_SZ = IDX_W;

    logic [IDX_W:0]   width;
    logic [IDX_W-1:0] top_idx;
    logic [PIX_W-1:0] wmask;
    logic [PIX_W-1:0] s_t;
    logic [PIX_W-1:0] d_t;
    logic [PIX_W-1:0] c_t;
    logic [4:0]       op;
    logic [PIX_W-1:0] logic_y;
    logic [PIX_W-1:0] arith_y;
    logic [PIX_W-1:0] mix_y;
    logic [PIX_W-1:0] merged;
    logic             block;

    // Derive width, top bit index and truncation mask from the size code.
    always_comb begin
        if (int'(size_code) > MAX_SZ) width = (IDX_W+1)'(PIX_W);
        else                          width = (IDX_W+1)'(1) << size_code;
        top_idx = IDX_W'(width - 1'b1);
        wmask   = {PIX_W{1'b1}} >> (PIX_W - int'(width));
        s_t     = src_pix & wmask;
        d_t     = dst_pix & wmask;
        c_t     = cc_color & wmask;
        op      = pat_bit ? fg_mix : bg_mix;
    end

    pix_logic_op #(.PIX_W(PIX_W)) i_logic (
        .op (op[3:0]),
        .s  (s_t),
        .d  (d_t),
        .y  (logic_y)
    );

    pix_arith_op #(.PIX_W(PIX_W)) i_arith (
        .op      (op[2:0]),
        .s       (s_t),
        .d       (d_t),
        .wmask   (wmask),
        .top_idx (top_idx),
        .cmask   (carry_mask),
        .y       (arith_y)
    );

    pix_cmp_gate #(.PIX_W(PIX_W)) i_cmp (
        .cond  (cc_cond),
        .dst   (d_t),
        .color (c_t),
        .block (block)
    );

    // Choose Boolean, arithmetic or pass-through, then apply the plane mask.
    always_comb begin
        if (!op[4])                 mix_y = logic_y;
        else if (op <= LAST_ARITH)  mix_y = arith_y;
        else                        mix_y = d_t;
        merged = ((mix_y & plane_mask) | (d_t & ~plane_mask)) & wmask;
    end

    // Register the pixel, write-enable and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_we    <= in_valid & ~block;
            out_pix   <= merged;
        end
    end
endmodule

// File: rtl/pix_mix_chk.sv
// Module: property checker for pix_mix_unit, attached by bind below.
module pix_mix_chk #(
    parameter int PIX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] dst_pix,
    input logic [2:0]       size_code,
    input logic [2:0]       cc_cond,
    input logic [PIX_W-1:0] plane_mask,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix,
    input logic             out_we
);
    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_we));
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 3'd3) |=> (out_pix[PIX_W-1:8] == '0));
    assert_always_true_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cc_cond == 3'd0) |=> !out_we);
    assert_always_false_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cc_cond == 3'd4) |=> out_we);
    assert_plane_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 3'd4) |=>
        (((out_pix ^ $past(dst_pix)) & ~$past(plane_mask)) == '0));
endmodule

bind pix_mix_unit pix_mix_chk #(.PIX_W(PIX_W)) i_pix_mix_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .dst_pix    (dst_pix),
    .size_code  (size_code),
    .cc_cond    (cc_cond),
    .plane_mask (plane_mask),
    .out_valid  (out_valid),
    .out_pix    (out_pix),
    .out_we     (out_we)
);

// File: tb/test_pix_mix_unit.sv
// Directed bench for pix_mix_unit: one task per scenario, each self-checking.
module test_pix_mix_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] src_pix = '0, dst_pix = '0, cc_color = '0;
    logic [15:0] plane_mask = '1, carry_mask = '1;
    logic [2:0]  size_code = 3'd3, cc_cond = 3'd4;
    logic [4:0]  fg_mix = 5'h3, bg_mix = 5'h3;
    logic        pat_bit = 1'b1;
    logic        out_valid, out_we;
    logic [15:0] out_pix;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_mix_unit i_pix_mix_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_pix(src_pix),
        .dst_pix(dst_pix), .size_code(size_code), .fg_mix(fg_mix), .bg_mix(bg_mix),
        .pat_bit(pat_bit), .cc_cond(cc_cond), .cc_color(cc_color),
        .plane_mask(plane_mask), .carry_mask(carry_mask),
        .out_valid(out_valid), .out_pix(out_pix), .out_we(out_we)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Present one pixel and sample the registered result after the next edge.
    task automatic apply();
        @(negedge clk);
        in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic mix_one(input logic [2:0] sz, input logic [4:0] code,
                           input logic [15:0] s, input logic [15:0] d);
        size_code = sz; fg_mix = code; pat_bit = 1'b1;
        src_pix = s; dst_pix = d; cc_cond = 3'd4;
        apply();
    endtask

    function automatic logic [7:0] bool_ref(input logic [3:0] c, input logic [7:0] s,
                                            input logic [7:0] d);
        case (c)
            4'h0: return 8'h00;  4'h1: return s & d;
            4'h2: return s & ~d; 4'h3: return s;
            4'h4: return ~s & d; 4'h5: return d;
            4'h6: return s ^ d;  4'h7: return s | d;
            4'h8: return ~(s | d); 4'h9: return ~(s ^ d);
            4'hA: return ~d;     4'hB: return s | ~d;
            4'hC: return ~s;     4'hD: return ~s | d;
            4'hE: return ~(s & d); default: return 8'hFF;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset valid", {15'b0, out_valid}, 16'h0);
        chk("R1 reset we", {15'b0, out_we}, 16'h0);
        chk("R1 reset pix", out_pix, 16'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_latency();
        mix_one(3'd3, 5'h3, 16'h0042, 16'h0011);
        chk("R1 valid", {15'b0, out_valid}, 16'h1);
        chk("R1 pix", out_pix, 16'h0042);
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R1 idle valid", {15'b0, out_valid}, 16'h0);
    endtask

    task automatic t_bool();
        for (int c = 0; c < 16; c++) begin
            mix_one(3'd3, 5'(c), 16'h00CA, 16'h00AC);
            chk($sformatf("R3 code %0d", c), out_pix, {8'h00, bool_ref(4'(c), 8'hCA, 8'hAC)});
        end
    endtask

    task automatic t_arith();
        mix_one(3'd3, 5'h10, 16'h00C8, 16'h0064); chk("R4 max", out_pix, 16'h00C8);
        mix_one(3'd3, 5'h11, 16'h00C8, 16'h0064); chk("R4 min", out_pix, 16'h0064);
        mix_one(3'd3, 5'h12, 16'h00C8, 16'h0064); chk("R5 add sat", out_pix, 16'h00FF);
        mix_one(3'd3, 5'h13, 16'h00C8, 16'h0064); chk("R5 d-s clamp", out_pix, 16'h0000);
        mix_one(3'd3, 5'h14, 16'h00C8, 16'h0064); chk("R5 s-d", out_pix, 16'h0064);
        mix_one(3'd3, 5'h12, 16'h0010, 16'h0030); chk("R5 add", out_pix, 16'h0040);
        mix_one(3'd3, 5'h13, 16'h0010, 16'h0030); chk("R5 d-s", out_pix, 16'h0020);
        mix_one(3'd3, 5'h14, 16'h0010, 16'h0030); chk("R5 s-d clamp", out_pix, 16'h0000);
        mix_one(3'd3, 5'h15, 16'h00C8, 16'h0064); chk("R6 avg", out_pix, 16'h0096);
        mix_one(3'd3, 5'h15, 16'h00FF, 16'h00FF); chk("R6 avg top carry", out_pix, 16'h00FF);
        mix_one(3'd2, 5'h12, 16'h0009, 16'h0008); chk("R5 add sat 4b", out_pix, 16'h000F);
        mix_one(3'd2, 5'h15, 16'h0009, 16'h0008); chk("R6 avg 4b", out_pix, 16'h0008);
        mix_one(3'd4, 5'h12, 16'hFFFF, 16'h0001); chk("R5 add sat 16b", out_pix, 16'hFFFF);
    endtask

    task automatic t_carry();
        carry_mask = 16'hFFF7;
        mix_one(3'd3, 5'h12, 16'h000F, 16'h0001); chk("R7 cut carry", out_pix, 16'h0000);
        carry_mask = 16'hFFFF;
        mix_one(3'd3, 5'h12, 16'h000F, 16'h0001); chk("R7 full carry", out_pix, 16'h0010);
    endtask

    task automatic t_reserved();
        mix_one(3'd3, 5'h16, 16'h0055, 16'h00A7); chk("R8 code 16", out_pix, 16'h00A7);
        mix_one(3'd3, 5'h1F, 16'h0055, 16'h003C); chk("R8 code 1F", out_pix, 16'h003C);
    endtask

    task automatic t_pattern();
        size_code = 3'd3; fg_mix = 5'h3; bg_mix = 5'h5; cc_cond = 3'd4;
        src_pix = 16'h0012; dst_pix = 16'h0034;
        pat_bit = 1'b1; apply(); chk("R9 fg", out_pix, 16'h0012);
        pat_bit = 1'b0; apply(); chk("R9 bg", out_pix, 16'h0034);
        pat_bit = 1'b1;
    endtask

    task automatic t_compare();
        size_code = 3'd3; fg_mix = 5'h3; pat_bit = 1'b1; cc_color = 16'h0050;
        for (int dv = 0; dv < 2; dv++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] dd;
                logic       hold;
                dd = (dv == 0) ? 8'h50 : 8'h60;
                case (c)
                    0: hold = 1'b1;       1: hold = dd > 8'h50;
                    2: hold = dd == 8'h50; 3: hold = dd < 8'h50;
                    4: hold = 1'b0;       5: hold = dd >= 8'h50;
                    6: hold = dd != 8'h50; default: hold = dd <= 8'h50;
                endcase
                dst_pix = {8'h00, dd}; cc_cond = 3'(c);
                apply();
                chk($sformatf("R10 cond %0d d=%h", c, dd), {15'b0, out_we}, {15'b0, ~hold});
            end
        end
        size_code = 3'd2; dst_pix = 16'h0035; cc_color = 16'h0005; cc_cond = 3'd2;
        apply(); chk("R2 R10 truncated compare", {15'b0, out_we}, 16'h0);
        cc_cond = 3'd4; cc_color = '0;
    endtask

    task automatic t_plane();
        plane_mask = 16'h0F0F;
        mix_one(3'd4, 5'h3, 16'hFFFF, 16'h0000); chk("R11 plane a", out_pix, 16'h0F0F);
        plane_mask = 16'hFF00;
        mix_one(3'd4, 5'h3, 16'hABCD, 16'h1234); chk("R11 plane b", out_pix, 16'hAB34);
        plane_mask = 16'hFFFF;
    endtask

    task automatic t_sizes();
        mix_one(3'd0, 5'h3, 16'hFFFF, 16'h0000); chk("R2 1 bit", out_pix, 16'h0001);
        mix_one(3'd1, 5'h3, 16'hFFFF, 16'h0000); chk("R2 2 bit", out_pix, 16'h0003);
        mix_one(3'd2, 5'hF, 16'h0000, 16'h0000); chk("R2 4 bit ones", out_pix, 16'h000F);
        mix_one(3'd7, 5'h3, 16'hFFFF, 16'h0000); chk("R2 code 7", out_pix, 16'hFFFF);
        mix_one(3'd0, 5'h12, 16'h0001, 16'h0001); chk("R2 R5 1 bit sat", out_pix, 16'h0001);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_bool();
        t_arith();
        t_carry();
        t_reserved();
        t_pattern();
        t_compare();
        t_plane();
        t_sizes();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule